// File: doc/BRIEF.md
# Pin Controller Register Bank

This block holds the per-pin configuration of a bank of general-purpose pins and drives the pad-side control lines from it. For every pin it records whether the controller logic or a peripheral function owns the pin. It also records output enable, output level, open-drain (multi-drive) mode, pull-up and pull-down. Software changes these settings over a simple memory-mapped bus. Each setting has its own set address and clear address, so one write can change any group of pins without a read-modify-write.

When a pin is handed to a peripheral, two plain read/write select registers together choose one of four functions for that pin. The chosen function's output enable and output value then drive the pad. The pad input levels pass through a synchronizer and can be read at any time, whatever the pin's direction. Pull-up and pull-down exclude each other in hardware.

Top module: `pinctl_bank`

## Requirements
- R1: After reset every pin is owned by the controller, outputs are disabled, output data and open-drain are 0, pull-ups are on, pull-downs are off, and both select registers are 0. Status reads are: ownership all ones, output enable 0, output data 0, open-drain 0, pull-up status 0, pull-down status all ones.
- R2: A write to a set address (ownership 0x00, output enable 0x04, output data 0x08, open-drain 0x0C) turns on exactly the bits that are 1 in the write data. All other bits keep their value, and the status address (base+2) reads back the result.
- R3: A write to a clear address (base+1 of the same four groups) turns off exactly the bits that are 1 in the write data. All other bits keep their value.
- R4: The select registers at 0x18 (low select bit) and 0x19 (high select bit) are written whole and read back unchanged.
- R5: When a pin's ownership bit is 1, pad_oe and pad_out follow its output-enable and output-data bits. When it is 0, they follow the function picked by {high,low} select bits: 00=A, 01=B, 10=C, 11=D. Function f drives pin i from bit f*N_PINS+i of periph_oe and periph_out. pad_fsel carries {high,low} for pin i at bits [2i+1:2i]. Every pad output changes one clock after the register that controls it.
- R6: Pull-up is set or cleared at 0x10/0x11 and pull-down at 0x14/0x15. Their status registers at 0x12 and 0x16 read 0 for a pin whose pull is active.
- R7: Turning on a pin's pull-up turns off its pull-down, and turning on the pull-down turns off the pull-up. pad_pullup and pad_pulldown are never both 1 on a pin.
- R8: The pin-data register at 0x1A returns pad_in passed through two synchronizer flops. A read answers with the level pad_in had two clocks before the read cycle.
- R9: Reads return data one clock after rd_en. Writes to status addresses, to the pin-data address or to unmapped addresses change nothing, and unmapped addresses read 0.
- R10: pad_opendrain, pad_pullup and pad_pulldown follow the open-drain, pull-up and pull-down settings one clock after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | N_PINS | Write data, one bit per pin |
| rdata | output | N_PINS | Read data, valid one clock after rd_en |
| pad_in | input | N_PINS | Pad input levels |
| periph_oe | input | 4*N_PINS | Output enables of functions A..D |
| periph_out | input | 4*N_PINS | Output values of functions A..D |
| pad_oe | output | N_PINS | Pad output enable |
| pad_out | output | N_PINS | Pad output value |
| pad_opendrain | output | N_PINS | Open-drain mode per pin |
| pad_pullup | output | N_PINS | Pull-up enable per pin |
| pad_pulldown | output | N_PINS | Pull-down enable per pin |
| pad_fsel | output | 2*N_PINS | Selected function code per pin |

## Verification
The hardest case to reach is four neighbouring peripheral-owned pins that each select a different function. For each of these pins, the function it selects drives the opposite value to the other three. A single wrong select decode or index therefore flips a visible pad bit. The stimulus releases four pins, writes both select registers so that the pins carry codes 00 to 11, and drives decoy values on the functions that are not selected. A second scenario changes pad_in and reads the pin data at once, to show that the two-flop delay holds.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int REG_AW = 5;

  // group index lives in addr[4:2], access kind in addr[1:0]
  localparam logic [2:0] GRP_OWN  = 3'd0;
  localparam logic [2:0] GRP_OE   = 3'd1;
  localparam logic [2:0] GRP_DAT  = 3'd2;
  localparam logic [2:0] GRP_OD   = 3'd3;
  localparam logic [2:0] GRP_PU   = 3'd4;
  localparam logic [2:0] GRP_PD   = 3'd5;
  localparam logic [2:0] GRP_MISC = 3'd6;

  localparam logic [1:0] SUB_SET  = 2'd0;
  localparam logic [1:0] SUB_CLR  = 2'd1;
  localparam logic [1:0] SUB_STAT = 2'd2;

  localparam logic [REG_AW-1:0] A_PU_SET  = {GRP_PU, SUB_SET};
  localparam logic [REG_AW-1:0] A_PU_CLR  = {GRP_PU, SUB_CLR};
  localparam logic [REG_AW-1:0] A_PU_STAT = {GRP_PU, SUB_STAT};
  localparam logic [REG_AW-1:0] A_PD_SET  = {GRP_PD, SUB_SET};
  localparam logic [REG_AW-1:0] A_PD_CLR  = {GRP_PD, SUB_CLR};
  localparam logic [REG_AW-1:0] A_PD_STAT = {GRP_PD, SUB_STAT};
  localparam logic [REG_AW-1:0] A_OD_SET  = {GRP_OD, SUB_SET};
  localparam logic [REG_AW-1:0] A_SEL_LO  = {GRP_MISC, 2'd0};
  localparam logic [REG_AW-1:0] A_SEL_HI  = {GRP_MISC, 2'd1};
  localparam logic [REG_AW-1:0] A_PIN_DAT = {GRP_MISC, 2'd2};
  localparam logic [REG_AW-1:0] A_NONE    = 5'h1F;

  typedef enum logic [1:0] {FN_A = 2'd0, FN_B = 2'd1, FN_C = 2'd2, FN_D = 2'd3} fn_sel_e;
endpackage

// File: rtl/pinctl_setclr.sv
module pinctl_setclr #(
  parameter int          N_PINS = 32,
  parameter logic [31:0] RST_ONE = 32'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [N_PINS-1:0] mask,
  output logic [N_PINS-1:0] q
);
  localparam logic [N_PINS-1:0] RST_VAL = RST_ONE[0] ? '1 : '0;

  always_ff @(posedge clk) begin
    if (rst)          q <= RST_VAL;
    else if (set_stb) q <= q | mask;
    else if (clr_stb) q <= q & ~mask;
  end
endmodule

// File: rtl/pinctl_pull.sv
module pinctl_pull #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_set,
  input  logic              up_clr,
  input  logic              dn_set,
  input  logic              dn_clr,
  input  logic [N_PINS-1:0] mask,
  output logic [N_PINS-1:0] up,
  output logic [N_PINS-1:0] dn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up <= '1;
      dn <= '0;
    end else if (up_set) begin
      up <= up | mask;
      dn <= dn & ~mask;
    end else if (dn_set) begin
      dn <= dn | mask;
      up <= up & ~mask;
    end else if (up_clr) begin
      up <= up & ~mask;
    end else if (dn_clr) begin
      dn <= dn & ~mask;
    end
  end
endmodule

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int N_PINS = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] d,
  output logic [N_PINS-1:0] q
);
  logic [N_PINS-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pinctl_padmux.sv
module pinctl_padmux
  import pinctl_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PINS-1:0]   own,
  input  logic [N_PINS-1:0]   oe,
  input  logic [N_PINS-1:0]   dat,
  input  logic [N_PINS-1:0]   sel_lo,
  input  logic [N_PINS-1:0]   sel_hi,
  input  logic [4*N_PINS-1:0] periph_oe,
  input  logic [4*N_PINS-1:0] periph_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [N_PINS-1:0]   pad_out
);
  logic [N_PINS-1:0] nxt_oe, nxt_out;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    fn_sel_e fn;
    logic    f_oe, f_out;
    always_comb begin
      fn = fn_sel_e'({sel_hi[i], sel_lo[i]});
      unique case (fn)
        FN_A: begin f_oe = periph_oe[i];            f_out = periph_out[i];            end
        FN_B: begin f_oe = periph_oe[N_PINS+i];     f_out = periph_out[N_PINS+i];     end
        FN_C: begin f_oe = periph_oe[2*N_PINS+i];   f_out = periph_out[2*N_PINS+i];   end
        default: begin f_oe = periph_oe[3*N_PINS+i]; f_out = periph_out[3*N_PINS+i]; end
      endcase
      nxt_oe[i]  = own[i] ? oe[i]  : f_oe;
      nxt_out[i] = own[i] ? dat[i] : f_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= nxt_oe;
      pad_out <= nxt_out;
    end
  end
endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
  import pinctl_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [N_PINS-1:0]   wdata,
  output logic [N_PINS-1:0]   rdata,
  input  logic [N_PINS-1:0]   pad_in,
  input  logic [4*N_PINS-1:0] periph_oe,
  input  logic [4*N_PINS-1:0] periph_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_opendrain,
  output logic [N_PINS-1:0]   pad_pullup,
  output logic [N_PINS-1:0]   pad_pulldown,
  output logic [2*N_PINS-1:0] pad_fsel
);
  localparam int N_SC = 4;  // own, oe, dat, od share the set/clear layout

  logic [2:0]        grp;
  logic [1:0]        sub;
  logic [N_PINS-1:0] cfg [N_SC];
  logic [N_PINS-1:0] pu, pd, sel_lo, sel_hi, pin_sync;

  assign grp = addr[REG_AW-1:2];
  assign sub = addr[1:0];

  for (genvar g = 0; g < N_SC; g++) begin : g_sc
    logic set_stb, clr_stb;
    assign set_stb = wr_en && (grp == 3'(g)) && (sub == SUB_SET);
    assign clr_stb = wr_en && (grp == 3'(g)) && (sub == SUB_CLR);
    pinctl_setclr #(.N_PINS(N_PINS), .RST_ONE((g == 0) ? 32'd1 : 32'd0)) u_reg (
      .clk(clk), .rst(rst), .set_stb(set_stb), .clr_stb(clr_stb),
      .mask(wdata), .q(cfg[g]));
  end

  pinctl_pull #(.N_PINS(N_PINS)) u_pull (
    .clk(clk), .rst(rst),
    .up_set(wr_en && addr == A_PU_SET), .up_clr(wr_en && addr == A_PU_CLR),
    .dn_set(wr_en && addr == A_PD_SET), .dn_clr(wr_en && addr == A_PD_CLR),
    .mask(wdata), .up(pu), .dn(pd));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_lo <= '0;
      sel_hi <= '0;
    end else if (wr_en) begin
      if (addr == A_SEL_LO) sel_lo <= wdata;
      if (addr == A_SEL_HI) sel_hi <= wdata;
    end
  end

  pinctl_sync #(.N_PINS(N_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync));

  pinctl_padmux #(.N_PINS(N_PINS)) u_mux (
    .clk(clk), .rst(rst),
    .own(cfg[GRP_OWN]), .oe(cfg[GRP_OE]), .dat(cfg[GRP_DAT]),
    .sel_lo(sel_lo), .sel_hi(sel_hi),
    .periph_oe(periph_oe), .periph_out(periph_out),
    .pad_oe(pad_oe), .pad_out(pad_out));

  logic [2*N_PINS-1:0] fsel_nxt;
  for (genvar i = 0; i < N_PINS; i++) begin : g_fsel
    assign fsel_nxt[2*i +: 2] = {sel_hi[i], sel_lo[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_opendrain <= '0;
      pad_pullup    <= '1;
      pad_pulldown  <= '0;
      pad_fsel      <= '0;
    end else begin
      pad_opendrain <= cfg[GRP_OD];
      pad_pullup    <= pu;
      pad_pulldown  <= pd;
      pad_fsel      <= fsel_nxt;
    end
  end

  logic [N_PINS-1:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    if (sub == SUB_STAT) begin
      unique case (grp)
        GRP_OWN, GRP_OE, GRP_DAT, GRP_OD: rd_nxt = cfg[grp[1:0]];
        GRP_PU:  rd_nxt = ~pu;
        GRP_PD:  rd_nxt = ~pd;
        GRP_MISC: rd_nxt = pin_sync;
        default: rd_nxt = '0;
      endcase
    end else if (addr == A_SEL_LO) begin
      rd_nxt = sel_lo;
    end else if (addr == A_SEL_HI) begin
      rd_nxt = sel_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/pinctl_bank_chk.sv
module pinctl_bank_chk
  import pinctl_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [REG_AW-1:0]   addr,
  input logic [N_PINS-1:0]   wdata,
  input logic [N_PINS-1:0]   rdata,
  input logic [N_PINS-1:0]   pad_in,
  input logic [N_PINS-1:0]   pad_oe,
  input logic [N_PINS-1:0]   pad_opendrain,
  input logic [N_PINS-1:0]   pad_pullup,
  input logic [N_PINS-1:0]   pad_pulldown
);
  // R7
  pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pullup & pad_pulldown) == '0);

  // R1
  reset_pads_chk: assert property (@(posedge clk)
    $fell(rst) |-> (pad_pullup == '1 && pad_pulldown == '0 && pad_oe == '0 && pad_opendrain == '0));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_NONE) |=> rdata == '0);

  // R2
  od_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OD_SET) |=> ##1 (pad_opendrain & $past(wdata, 2)) == $past(wdata, 2));

  // R7
  pu_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_PU_SET) |=> ##1 (pad_pulldown & $past(wdata, 2)) == '0);

  // R8
  pin_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_PIN_DAT && !$past(rst) && !$past(rst, 2)) |=> rdata == $past(pad_in, 3));
endmodule

bind pinctl_bank pinctl_bank_chk #(.N_PINS(N_PINS)) u_chk (.*);

// File: tb/tb_pinctl_bank.sv
module tb_pinctl_bank;
  localparam int N = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata, pad_in = '0;
  logic [4*N-1:0] periph_oe = '0, periph_out = '0;
  logic [N-1:0] pad_oe, pad_out, pad_opendrain, pad_pullup, pad_pulldown;
  logic [2*N-1:0] pad_fsel;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinctl_bank #(.N_PINS(N)) dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    bus_rd(a, v);
    check(req, 64'(v), 64'(exp));
  endtask

  task automatic t_reset();
    rd_check("R1 own", 5'h02, '1);
    rd_check("R1 oe", 5'h06, '0);
    rd_check("R1 dat", 5'h0A, '0);
    rd_check("R1 od", 5'h0E, '0);
    rd_check("R1 pu", 5'h12, '0);
    rd_check("R1 pd", 5'h16, '1);
    rd_check("R1 sel", 5'h18, '0);
    check("R1 pads", {pad_pullup, pad_oe}, {{N{1'b1}}, {N{1'b0}}});
  endtask

  task automatic t_setclr();
    bus_wr(5'h04, 32'h0000_00F0);
    bus_wr(5'h04, 32'h0000_0003);
    rd_check("R2 oe set", 5'h06, 32'h0000_00F3);
    bus_wr(5'h05, 32'h0000_0010);
    rd_check("R3 oe clr", 5'h06, 32'h0000_00E3);
    bus_wr(5'h08, 32'h8000_0001);
    rd_check("R2 dat set", 5'h0A, 32'h8000_0001);
    bus_wr(5'h09, 32'h8000_0000);
    rd_check("R3 dat clr", 5'h0A, 32'h0000_0001);
    bus_wr(5'h0C, 32'h0000_0300);
    @(negedge clk);
    check("R10 opendrain", 64'(pad_opendrain), 64'h300);
    bus_wr(5'h0D, 32'h0000_0100);
    rd_check("R3 od clr", 5'h0E, 32'h0000_0200);
    bus_wr(5'h01, 32'h0000_000F);
    rd_check("R3 own clr", 5'h02, 32'hFFFF_FFF0);
    bus_wr(5'h00, 32'h0000_0003);
    rd_check("R2 own set", 5'h02, 32'hFFFF_FFF3);
    bus_wr(5'h00, '1);
    bus_wr(5'h05, '1);
    bus_wr(5'h09, '1);
    bus_wr(5'h0D, '1);
  endtask

  task automatic t_select();
    bus_wr(5'h18, 32'hA5A5_0F0F);
    bus_wr(5'h19, 32'h1234_8001);
    rd_check("R4 sel lo", 5'h18, 32'hA5A5_0F0F);
    rd_check("R4 sel hi", 5'h19, 32'h1234_8001);
    bus_wr(5'h18, '0);
    bus_wr(5'h19, '0);
  endtask

  task automatic t_pads();
    // function f pin i at bit f*N+i; selected: A pin0=1, B pin1=1, C pin2=0, D pin3=1
    periph_oe = '0;
    periph_oe[0] = 1'b1;
    periph_oe[N+1] = 1'b1;
    periph_oe[2] = 1'b1; periph_oe[N+2] = 1'b1; periph_oe[3*N+2] = 1'b1;
    periph_oe[3*N+3] = 1'b1;
    periph_out = ~periph_oe;
    bus_wr(5'h18, 32'h0000_000A);
    bus_wr(5'h19, 32'h0000_000C);
    bus_wr(5'h04, 32'h0000_0010);
    bus_wr(5'h08, 32'h0000_0010);
    bus_wr(5'h01, 32'h0000_000F);
    @(negedge clk);
    check("R5 periph oe", 64'(pad_oe), 64'h1B);
    check("R5 periph out", 64'(pad_out), 64'h14);
    check("R5 fsel", 64'(pad_fsel), 64'hE4);
    bus_wr(5'h00, 32'h0000_000F);
    @(negedge clk);
    check("R5 owned oe", 64'(pad_oe), 64'h10);
    check("R5 owned out", 64'(pad_out), 64'h10);
  endtask

  task automatic t_pull();
    bus_wr(5'h14, 32'h0000_0003);
    rd_check("R6 pd stat", 5'h16, 32'hFFFF_FFFC);
    rd_check("R7 pu off", 5'h12, 32'h0000_0003);
    check("R7 pad pd", 64'(pad_pulldown), 64'h3);
    bus_wr(5'h10, 32'h0000_0001);
    rd_check("R7 pd off", 5'h16, 32'hFFFF_FFFD);
    rd_check("R6 pu stat", 5'h12, 32'h0000_0002);
    bus_wr(5'h11, 32'h0000_0004);
    rd_check("R6 pu clr", 5'h12, 32'h0000_0006);
    @(negedge clk);
    check("R10 pad pu", 64'(pad_pullup), 64'(32'hFFFF_FFF9));
  endtask

  task automatic t_sync();
    logic [N-1:0] v;
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rd_check("R8 pin data", 5'h1A, 32'hDEAD_BEEF);
    pad_in = 32'h1234_5678;
    bus_rd(5'h1A, v);
    check("R8 latency", 64'(v), 64'(32'hDEAD_BEEF));
    repeat (2) @(negedge clk);
    rd_check("R8 new data", 5'h1A, 32'h1234_5678);
  endtask

  task automatic t_ignore();
    bus_wr(5'h06, '1);
    bus_wr(5'h12, '1);
    bus_wr(5'h1A, '1);
    bus_wr(5'h1F, '1);
    rd_check("R9 oe stat", 5'h06, 32'h0000_0010);
    rd_check("R9 pu stat", 5'h12, 32'h0000_0006);
    rd_check("R9 unmapped", 5'h1F, '0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_setclr();
    t_select();
    t_pads();
    t_pull();
    t_sync();
    t_ignore();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule